// File: doc/BRIEF.md
# LIN Frame Timeout Watchdog

This block watches the receive side of a LIN slave node and decides when the node must go back to waiting for a new header. It runs in one of two policies, chosen when a countdown is started.

In reception mode the node expects a response of known length. A bit budget is loaded from the expected byte count. It is 1.4 times the expected bits, with 10 bits per byte for the start and stop bits. The budget is then drawn down in coarse steps, once every five bit times. The countdown ends in one of two ways. The frame-complete strobe ends it normally. If the budget runs out first, the bus is taken as stalled.

In ignore mode the received identifier is not one the node serves. The block then only needs to see when the foreign frame is over. Every received byte rearms a 15 bit-time silence window. When that window runs out, the frame is treated as finished. Either ending produces a one-clock resynchronisation request, and the block then sits idle until it is started again.

Top module: `lin_frame_watchdog`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `resync_req` is low and the block is idle.
- R2: A `start` with `start_mode` = 0 selects reception mode. It loads a budget of B + ceil(2·B/5) bits, where B = 10 × `exp_bytes`.
- R3: In reception mode the budget is checked on every fifth `bit_tick` after the start, and 5 is taken off at each check. `resync_req` pulses on the clock after tick number 5 × ceil(budget/5). For example, 1 byte pulses at tick 15 and 2 bytes at tick 30.
- R4: The reception countdown saturates at zero. A budget of 0 (`exp_bytes` = 0) expires at the first check, on tick 5.
- R5: `frame_done` in reception mode gives a `resync_req` pulse on the next clock and ends the countdown. If it falls in the same cycle as the expiring check, exactly one pulse is produced.
- R6: A `start` with `start_mode` = 1 selects ignore mode. With no received byte, `resync_req` pulses on the clock after the 15th `bit_tick`.
- R7: In ignore mode, `byte_rx` reloads the silence window to 15 bit times. When `byte_rx` and `bit_tick` fall in the same cycle, the reload wins, and 15 further ticks are needed.
- R8: `resync_req` is high for exactly one clock. After it, the block is idle, and `bit_tick`, `byte_rx` and `frame_done` cause no pulse until the next `start`.
- R9: `frame_done` in ignore mode and `byte_rx` in reception mode have no effect on when the pulse comes.
- R10: A `start` overrides any countdown in progress, including a same-cycle `frame_done`. It also restarts the five-tick check phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_tick | input | 1 | One-clock strobe per bit time |
| byte_rx | input | 1 | One-clock strobe per byte received on the bus |
| frame_done | input | 1 | One-clock strobe: reception frame completed normally |
| start | input | 1 | One-clock strobe: begin a countdown |
| start_mode | input | 1 | Policy at `start`: 0 = reception budget, 1 = ignore silence |
| exp_bytes | input | BYTES_W | Expected response byte count, sampled at `start` |
| resync_req | output | 1 | Registered one-clock request to return to header sync |

## Verification
Two pairs of functions can fall in the same cycle. The first pair is the normal frame-complete ending and the budget expiry. The bench raises `frame_done` together with the tick that makes the final check. It then expects a single pulse on the next clock and none after it. The second pair is the silence reload and the silence decrement. The bench drives `byte_rx` and `bit_tick` together one tick before the window would run out, and requires the pulse to come a full 15 ticks later. A scoreboard of expected pulse cycles judges both cases. Any pulse off its cycle, or any extra pulse, is reported.

// File: rtl/lfw_pkg.sv
package lfw_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RECV = 2'd1,
    ST_IGN  = 2'd2
  } lfw_state_e;
endpackage

// File: rtl/lfw_budget.sv
// Reception budget: bits + ceil(NUM*bits/DEN), bits = bytes * BITS_PER_BYTE.
module lfw_budget #(
  parameter int BYTES_W       = 4,
  parameter int CNT_W         = 8,
  parameter int BITS_PER_BYTE = 10,
  parameter int BUD_NUM       = 2,
  parameter int BUD_DEN       = 5
) (
  input  logic [BYTES_W-1:0] nbytes,
  output logic [CNT_W-1:0]   budget
);
  localparam int W = CNT_W + $clog2(BUD_NUM + 1) + 1;

  logic [W-1:0] bits;
  logic [W-1:0] extra;

  always_comb begin
    bits   = W'(nbytes) * W'(BITS_PER_BYTE);
    extra  = (bits * W'(BUD_NUM) + W'(BUD_DEN - 1)) / W'(BUD_DEN);
    budget = CNT_W'(bits + extra);
  end
endmodule

// File: rtl/lfw_step_div.sv
// Emits a step on every STEP-th tick while enabled; clr restarts the phase.
module lfw_step_div #(
  parameter int STEP = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic en,
  input  logic tick,
  output logic step
);
  localparam int DW = (STEP > 1) ? $clog2(STEP) : 1;

  logic [DW-1:0] phase;

  assign step = en && tick && (phase == DW'(STEP - 1));

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      phase <= '0;
    end else if (en && tick) begin
      phase <= step ? '0 : phase + 1'b1;
    end
  end

  // R3: the phase never leaves its range
  p_phase_range_r3: assert property (@(posedge clk) disable iff (rst)
    phase < DW'(STEP));
endmodule

// File: rtl/lin_frame_watchdog.sv
module lin_frame_watchdog
  import lfw_pkg::*;
#(
  parameter int BYTES_W       = 4,
  parameter int BITS_PER_BYTE = 10,
  parameter int BUD_NUM       = 2,
  parameter int BUD_DEN       = 5,
  parameter int CHECK_STEP    = 5,
  parameter int SILENCE_BITS  = 15
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               bit_tick,
  input  logic               byte_rx,
  input  logic               frame_done,
  input  logic               start,
  input  logic               start_mode,
  input  logic [BYTES_W-1:0] exp_bytes,
  output logic               resync_req
);
  localparam int MAX_BITS = ((1 << BYTES_W) - 1) * BITS_PER_BYTE;
  localparam int MAX_BUD  = MAX_BITS + (BUD_NUM * MAX_BITS + BUD_DEN - 1) / BUD_DEN;
  localparam int CNT_MAX  = (MAX_BUD > SILENCE_BITS) ? MAX_BUD : SILENCE_BITS;
  localparam int CNT_W    = $clog2(CNT_MAX + 1);
  localparam logic [CNT_W-1:0] STEP_C = CNT_W'(CHECK_STEP);
  localparam logic [CNT_W-1:0] SIL_C  = CNT_W'(SILENCE_BITS);
  localparam logic [CNT_W-1:0] ONE_C  = CNT_W'(1);

  lfw_state_e       state;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] budget;
  logic             step;
  logic             resync_q;

  lfw_budget #(
    .BYTES_W      (BYTES_W),
    .CNT_W        (CNT_W),
    .BITS_PER_BYTE(BITS_PER_BYTE),
    .BUD_NUM      (BUD_NUM),
    .BUD_DEN      (BUD_DEN)
  ) u_budget (
    .nbytes(exp_bytes),
    .budget(budget)
  );

  lfw_step_div #(
    .STEP(CHECK_STEP)
  ) u_div (
    .clk (clk),
    .rst (rst),
    .clr (start),
    .en  (state == ST_RECV),
    .tick(bit_tick),
    .step(step)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      resync_q <= 1'b0;
    end else begin
      resync_q <= 1'b0;
      if (start) begin
        state <= start_mode ? ST_IGN : ST_RECV;
        cnt   <= start_mode ? SIL_C : budget;
      end else begin
        case (state)
          ST_RECV: begin
            if (frame_done) begin
              resync_q <= 1'b1;
              state    <= ST_IDLE;
            end else if (step) begin
              if (cnt <= STEP_C) begin
                resync_q <= 1'b1;
                state    <= ST_IDLE;
                cnt      <= '0;
              end else begin
                cnt <= cnt - STEP_C;
              end
            end
          end
          ST_IGN: begin
            if (byte_rx) begin
              cnt <= SIL_C;
            end else if (bit_tick) begin
              if (cnt <= ONE_C) begin
                resync_q <= 1'b1;
                state    <= ST_IDLE;
                cnt      <= '0;
              end else begin
                cnt <= cnt - ONE_C;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign resync_req = resync_q;

  // R2: a reception start loads the computed budget
  p_budget_load_r2: assert property (@(posedge clk) disable iff (rst)
    (start && !start_mode) |=> (state == ST_RECV) && (cnt == $past(budget)));

  // R3: a check that finds the budget spent raises the request
  p_expire_r3: assert property (@(posedge clk) disable iff (rst)
    (state == ST_RECV && !start && !frame_done && step && cnt <= STEP_C) |=> resync_req);

  // R3: a check with budget left takes off exactly one step
  p_step_dec_r3: assert property (@(posedge clk) disable iff (rst)
    (state == ST_RECV && !start && !frame_done && step && cnt > STEP_C)
      |=> (cnt == $past(cnt) - STEP_C) && !resync_req);

  // R6: the last silent tick raises the request
  p_silence_r6: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IGN && !start && !byte_rx && bit_tick && cnt <= ONE_C) |=> resync_req);

  // R7: a received byte rearms the silence window
  p_reload_r7: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IGN && !start && byte_rx) |=> (cnt == SIL_C) && !resync_req);

  // R8: the request lasts one clock and leaves the block idle
  p_single_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    resync_req |=> !resync_req);
  p_idle_after_r8: assert property (@(posedge clk) disable iff (rst)
    resync_req |-> (state == ST_IDLE));

  // R10: a start never produces a request
  p_start_wins_r10: assert property (@(posedge clk) disable iff (rst)
    start |=> !resync_req);
endmodule

// File: tb/lin_frame_watchdog_tb.sv
`timescale 1ns/1ps
module lin_frame_watchdog_tb;
  localparam int BYTES_W = 4;

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic               bit_tick = 1'b0;
  logic               byte_rx = 1'b0;
  logic               frame_done = 1'b0;
  logic               start = 1'b0;
  logic               start_mode = 1'b0;
  logic [BYTES_W-1:0] exp_bytes = '0;
  logic               resync_req;

  int    cyc = 0;
  int    checks = 0;
  int    failures = 0;
  int    q_cyc[$];
  string q_tag[$];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  lin_frame_watchdog #(.BYTES_W(BYTES_W)) u_dut (
    .clk(clk), .rst(rst), .bit_tick(bit_tick), .byte_rx(byte_rx),
    .frame_done(frame_done), .start(start), .start_mode(start_mode),
    .exp_bytes(exp_bytes), .resync_req(resync_req)
  );

  task automatic drv(input logic t, input logic b, input logic d,
                     input logic s, input logic m, input int nb);
    @(posedge clk); #1;
    bit_tick = t; byte_rx = b; frame_done = d;
    start = s; start_mode = m; exp_bytes = BYTES_W'(nb);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drv(0, 0, 0, 0, 0, 0);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) drv(1, 0, 0, 0, 0, 0);
  endtask

  task automatic expect_pulse(input string tag);
    q_cyc.push_back(cyc + 1);
    q_tag.push_back(tag);
  endtask

  // tick n times; the last tick is expected to raise the request
  task automatic ticks_expect(input int n, input string tag);
    ticks(n - 1);
    drv(1, 0, 0, 0, 0, 0);
    expect_pulse(tag);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst) begin
      checks++;
      if (resync_req !== 1'b0) begin
        failures++;
        $display("FAIL R1 reset: resync_req actual=%b expected=0", resync_req);
      end
    end else if (resync_req === 1'b1) begin
      if (q_cyc.size() > 0 && q_cyc[0] == cyc) begin
        checks++;
        void'(q_cyc.pop_front());
        void'(q_tag.pop_front());
      end else begin
        checks++;
        failures++;
        $display("FAIL R8 unexpected pulse: resync_req actual=1 expected=0 at cycle %0d", cyc);
      end
    end else if (q_cyc.size() > 0 && q_cyc[0] <= cyc) begin
      checks++;
      failures++;
      $display("FAIL %s missed pulse: resync_req actual=0 expected=1 at cycle %0d",
               q_tag[0], q_cyc[0]);
      void'(q_cyc.pop_front());
      void'(q_tag.pop_front());
    end
  end

  initial begin
    #200000;
    failures++;
    $display("FAIL watchdog: run did not finish actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    idle(3);
    @(posedge clk); #1 rst = 1'b0;
    idle(2); // R1: no pulse right after reset (monitor)

    // R2 R3: one byte -> budget 14 -> pulse on tick 15
    drv(0, 0, 0, 1, 0, 1);
    ticks_expect(15, "R3");
    idle(3);

    // R2 R3: two bytes -> budget 28 -> pulse on tick 30
    drv(0, 0, 0, 1, 0, 2);
    ticks_expect(30, "R2");
    idle(2);

    // R4: zero bytes -> expires at first check, tick 5
    drv(0, 0, 0, 1, 0, 0);
    ticks_expect(5, "R4");
    idle(2);

    // R2: fifteen bytes -> 150 + 60 = 210 -> tick 210
    drv(0, 0, 0, 1, 0, 15);
    ticks_expect(210, "R2");
    idle(2);

    // R5: normal completion mid-frame, then R8 idle ignores everything
    drv(0, 0, 0, 1, 0, 3);
    ticks(7);
    drv(0, 0, 1, 0, 0, 0);
    expect_pulse("R5");
    ticks(40);
    drv(0, 1, 0, 0, 0, 0);
    drv(0, 0, 1, 0, 0, 0);
    idle(3);

    // R5: frame_done in the same cycle as the expiring check -> one pulse
    drv(0, 0, 0, 1, 0, 1);
    ticks(14);
    drv(1, 0, 1, 0, 0, 0);
    expect_pulse("R5");
    ticks(10);

    // R9: byte_rx in reception mode has no effect
    drv(0, 0, 0, 1, 0, 1);
    ticks(7);
    drv(0, 1, 0, 0, 0, 0);
    ticks_expect(8, "R9");
    idle(2);

    // R6: ignore mode, 15 silent ticks
    drv(0, 0, 0, 1, 1, 0);
    ticks_expect(15, "R6");
    idle(2);

    // R7: byte after 10 ticks rearms a full window
    drv(0, 0, 0, 1, 1, 0);
    ticks(10);
    drv(0, 1, 0, 0, 0, 0);
    ticks_expect(15, "R7");
    idle(2);

    // R7: byte and tick in the same cycle, one tick before expiry
    drv(0, 0, 0, 1, 1, 0);
    ticks(14);
    drv(1, 1, 0, 0, 0, 0);
    ticks_expect(15, "R7");
    idle(2);

    // R9: frame_done in ignore mode has no effect
    drv(0, 0, 0, 1, 1, 0);
    ticks(5);
    drv(0, 0, 1, 0, 0, 0);
    ticks_expect(10, "R9");
    idle(2);

    // R10: start into ignore mode overrides a reception countdown
    drv(0, 0, 0, 1, 0, 1);
    ticks(12);
    drv(0, 0, 0, 1, 1, 0);
    ticks_expect(15, "R10");
    idle(2);

    // R10: start with same-cycle frame_done wins; check phase restarts
    drv(0, 0, 0, 1, 0, 2);
    ticks(3);
    drv(0, 0, 1, 1, 0, 1);
    ticks_expect(15, "R10");
    idle(5);

    checks++;
    if (q_cyc.size() != 0) begin
      failures++;
      $display("FAIL R8 scoreboard: pending actual=%0d expected=0", q_cyc.size());
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule